// File: doc/BRIEF.md
# Cascaded Real-Time-Clock Prescale Stage

This block is the second stage of a two-stage real-time-clock prescaler. It counts single-cycle tick pulses from one of two sources: a 32 kHz crystal tick or the output tick of the first prescale stage. From that count it makes two things. The first is a divided output tick whose ratio is chosen by software. The second is a periodic interval event that sets an interrupt flag. The interval is chosen separately from the output ratio.

Software reaches the block through one 16-bit control word. The word holds the source choice, the divide code, a run/stop bit, the interval code, an interrupt enable and the interrupt flag. When the calendar-mode input is high, the block ignores the source, divide and stop fields. The stage then counts first-stage ticks, divides by a fixed 128, and is stopped only by a dedicated calendar-hold input. The block runs in one clock domain. It contains an 8-bit counter with one falling-edge tap per bit, a multiplexer for each tap selection, and a two-flop reset release.

Top module: `rtcps_stage2`

## Requirements
- R1: After reset, `ctl_rdata` reads 0x0100: the stop bit (bit 8) is 1 and every other bit is 0. `out_tick` and `irq` are low.
- R2: With `cal_mode` low and counting enabled, `out_tick` gives one single-cycle pulse per 2^(d+1) selected ticks, where d is bits 13:11. The pulse comes on the tick where counter bit d falls from 1 to 0 and appears one clock after that tick.
- R3: The interval code i in bits 4:2 sets the flag once per 2^(i+1) counted ticks, on the tick where counter bit i falls. The interval does not depend on the divide code.
- R4: Bits 15:14 pick the source. Codes 00 and 01 count `xtal_tick`. Codes 10 and 11 count `stage1_tick`.
- R5: With `cal_mode` high, the stage counts `stage1_tick` and divides its output by 128, whatever bits 15:14 and 13:11 hold.
- R6: With `cal_mode` low, a 1 in bit 8 freezes the counter and 0 lets it run. With `cal_mode` high, bit 8 has no effect and `cal_hold` high freezes the counter.
- R7: Bits 10:9 and 7:5 always read 0 and ignore writes. All other fields read back what was last written.
- R8: `irq` is high exactly when the flag (bit 0) and the enable (bit 1) are both 1.
- R9: Software may write the flag to 0 or 1. If an interval event happens in the same cycle as a write that clears the flag, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; released internally after two clocks |
| xtal_tick | input | 1 | Single-cycle crystal tick enable |
| stage1_tick | input | 1 | Single-cycle tick from the first prescale stage |
| cal_mode | input | 1 | Calendar mode: forces the source, the /128 ratio and external hold |
| cal_hold | input | 1 | Stops the counter while in calendar mode |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Control word read data |
| out_tick | output | 1 | Divided output tick, single-cycle pulse |
| irq | output | 1 | Interrupt request |

## Verification
The in-design properties assume that `xtal_tick` and `stage1_tick` are one-cycle enables sampled on the system clock. They also assume that `cal_mode` and `cal_hold` change only on clock boundaries, so a counted tick and the mode that governed it fall in the same cycle. The stimulus drives every input half a period away from the active edge. It runs the crystal tick in every cycle and the first-stage tick in every other cycle, so the two sources always give different counts. It changes the mode and the control word only between measurement windows. Those windows are whole multiples of 256 ticks, so the expected pulse counts do not depend on where the counter started.

// File: rtl/rtcps_pkg.sv
package rtcps_pkg;
  localparam int CNT_W    = 8;
  localparam int CODE_W   = $clog2(CNT_W);
  localparam int SEL_W    = 2;
  localparam int CTL_W    = 16;
  localparam int CAL_CODE = 6;

  typedef struct packed {
    logic [SEL_W-1:0]  src_sel;
    logic [CODE_W-1:0] div_code;
    logic              stop;
    logic [CODE_W-1:0] ivl_code;
    logic              ie;
    logic              flag;
  } ctl_t;

  function automatic logic [CNT_W-1:0] low_mask(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] m;
    for (int i = 0; i < CNT_W; i++) m[i] = (i <= int'(code));
    return m;
  endfunction
endpackage

// File: rtl/rtcps_ctl_reg.sv
module rtcps_ctl_reg
  import rtcps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             ivl_evt,
  output ctl_t             ctl,
  output logic [CTL_W-1:0] rdata
);
  ctl_t ctl_q, ctl_d;
  logic unused_rsvd;

  assign unused_rsvd = ^{wdata[10:9], wdata[7:5]};

  always_comb begin
    ctl_d = ctl_q;
    if (we) begin
      ctl_d.src_sel  = wdata[15:14];
      ctl_d.div_code = wdata[13:11];
      ctl_d.stop     = wdata[8];
      ctl_d.ivl_code = wdata[4:2];
      ctl_d.ie       = wdata[1];
      ctl_d.flag     = wdata[0];
    end
    if (ivl_evt) ctl_d.flag = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q.src_sel  <= '0;
      ctl_q.div_code <= '0;
      ctl_q.stop     <= 1'b1;
      ctl_q.ivl_code <= '0;
      ctl_q.ie       <= 1'b0;
      ctl_q.flag     <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  assign ctl = ctl_q;

  always_comb begin
    rdata        = '0;
    rdata[15:14] = ctl_q.src_sel;
    rdata[13:11] = ctl_q.div_code;
    rdata[8]     = ctl_q.stop;
    rdata[4:2]   = ctl_q.ivl_code;
    rdata[1]     = ctl_q.ie;
    rdata[0]     = ctl_q.flag;
  end

  assert_hw_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_evt |=> ctl_q.flag);
  assert_write_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ctl_q.stop == $past(wdata[8])) && (ctl_q.ie == $past(wdata[1])));
endmodule

// File: rtl/rtcps_src_sel.sv
module rtcps_src_sel
  import rtcps_pkg::*;
(
  input  logic              xtal_tick,
  input  logic              stage1_tick,
  input  logic              cal_mode,
  input  logic              cal_hold,
  input  ctl_t              ctl,
  output logic              adv,
  output logic [CODE_W-1:0] div_eff
);
  logic src_tick;
  logic run;

  always_comb begin
    if (cal_mode) begin
      src_tick = stage1_tick;
      run      = !cal_hold;
      div_eff  = CODE_W'(CAL_CODE);
    end else begin
      src_tick = ctl.src_sel[SEL_W-1] ? stage1_tick : xtal_tick;
      run      = !ctl.stop;
      div_eff  = ctl.div_code;
    end
    adv = run & src_tick;
  end
endmodule

// File: rtl/rtcps_count.sv
module rtcps_count
  import rtcps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [CODE_W-1:0] div_code,
  input  logic [CODE_W-1:0] ivl_code,
  output logic              out_tick,
  output logic              ivl_evt,
  output logic [CNT_W-1:0]  cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] fall_vec;
  logic             out_q, out_d;

  for (genvar k = 0; k < CNT_W; k++) begin : g_tap
    assign fall_vec[k] = adv & (&cnt_q[k:0]);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (adv) cnt_d = cnt_q + 1'b1;
    out_d   = fall_vec[div_code];
    ivl_evt = fall_vec[ivl_code];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign out_tick = out_q;
  assign cnt      = cnt_q;

  assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt_q));
  assert_out_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_tick |-> ((cnt_q & low_mask($past(div_code))) == '0) && $past(adv));
endmodule

// File: rtl/rtcps_stage2.sv
module rtcps_stage2
  import rtcps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xtal_tick,
  input  logic             stage1_tick,
  input  logic             cal_mode,
  input  logic             cal_hold,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic             out_tick,
  output logic             irq
);
  logic              rst_s1, rst_s2;
  ctl_t              ctl;
  logic              adv;
  logic [CODE_W-1:0] div_eff;
  logic              ivl_evt;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  rtcps_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_s2), .we(ctl_we), .wdata(ctl_wdata),
    .ivl_evt(ivl_evt), .ctl(ctl), .rdata(ctl_rdata)
  );

  rtcps_src_sel u_sel (
    .xtal_tick(xtal_tick), .stage1_tick(stage1_tick), .cal_mode(cal_mode),
    .cal_hold(cal_hold), .ctl(ctl), .adv(adv), .div_eff(div_eff)
  );

  rtcps_count u_cnt (
    .clk(clk), .rst_n(rst_s2), .adv(adv), .div_code(div_eff),
    .ivl_code(ctl.ivl_code), .out_tick(out_tick), .ivl_evt(ivl_evt), .cnt(cnt)
  );

  assign irq = ctl.flag & ctl.ie;

  assert_cal_counts_stage1_R5: assert property (@(posedge clk) disable iff (!rst_s2)
    (cal_mode && !cal_hold && stage1_tick) |=> (cnt != $past(cnt)));
  assert_cal_ignores_xtal_R5: assert property (@(posedge clk) disable iff (!rst_s2)
    (cal_mode && !stage1_tick) |=> $stable(cnt));
  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_s2)
    irq |-> ctl_rdata[1]);
endmodule

// File: tb/rtcps_stage2_bench.sv
module rtcps_stage2_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xtal_tick = 1'b0, stage1_tick = 1'b0;
  logic        cal_mode = 1'b0, cal_hold = 1'b0;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic        out_tick, irq;

  int checks = 0, failures = 0;
  bit cmp_on = 0;
  bit x_on = 0, s_on = 0, phase = 0;
  int n_out = 0;

  // behavioural reference state
  int m_sync = 0, m_cnt = 0, m_sel = 0, m_div = 0, m_hold = 1, m_ivl = 0, m_ie = 0, m_flag = 0, m_out = 0;

  always #5 clk = ~clk;

  rtcps_stage2 u_rtcps_stage2 (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .stage1_tick(stage1_tick),
    .cal_mode(cal_mode), .cal_hold(cal_hold), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .out_tick(out_tick), .irq(irq)
  );

  function automatic bit fall_at(int cnt, int k);
    return ((cnt % (2 << k)) == ((2 << k) - 1));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = 0; m_cnt = 0; m_sel = 0; m_div = 0; m_hold = 1;
      m_ivl = 0; m_ie = 0; m_flag = 0; m_out = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      bit run, src, adv;
      int dk;
      run = cal_mode ? !cal_hold : (m_hold == 0);
      src = (cal_mode || m_sel >= 2) ? stage1_tick : xtal_tick;
      adv = run && src;
      dk  = cal_mode ? 6 : m_div;
      m_out = (adv && fall_at(m_cnt, dk)) ? 1 : 0;
      if (ctl_we) begin
        m_sel = ctl_wdata[15:14]; m_div = ctl_wdata[13:11]; m_hold = ctl_wdata[8];
        m_ivl = ctl_wdata[4:2];   m_ie = ctl_wdata[1];       m_flag = ctl_wdata[0];
      end
      if (adv && fall_at(m_cnt, (ctl_we ? m_ivl : m_ivl))) m_flag = 1;
      if (adv) m_cnt = (m_cnt + 1) % 256;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      int exp_rd;
      exp_rd = (m_sel << 14) | (m_div << 11) | (m_hold << 8) | (m_ivl << 2) | (m_ie << 1) | m_flag;
      check("R2 R5 out_tick vs model", int'(out_tick), m_out);
      check("R3 R7 R9 control readback vs model", int'(ctl_rdata), exp_rd);
      check("R8 irq vs model", int'(irq), m_flag & m_ie);
    end
    n_out += int'(out_tick);
  end

  task automatic step();
    @(negedge clk);
    ctl_we      = 1'b0;
    xtal_tick   = x_on;
    stage1_tick = s_on && phase;
    phase       = !phase;
  endtask

  task automatic wr(logic [15:0] v);
    step();
    ctl_we = 1'b1;
    ctl_wdata = v;
  endtask

  // reprogram with ticks paused, then count pulses over a window
  task automatic window(logic [15:0] v, int steps, int exp_pulses, string tag);
    x_on = 0; s_on = 0;
    wr(v);
    step(); step();
    n_out = 0;
    x_on = 1; s_on = 1;
    for (int i = 0; i < steps; i++) step();
    x_on = 0; s_on = 0;
    step(); step();
    check(tag, n_out, exp_pulses);
  endtask

  initial begin
    #(150000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset control word", int'(ctl_rdata), 16'h0100);
    check("R1 reset out_tick", int'(out_tick), 0);
    check("R1 reset irq", int'(irq), 0);
    cmp_on = 1;

    // R6: held by reset value of stop bit, no pulses while ticking
    n_out = 0; x_on = 1; s_on = 1;
    for (int i = 0; i < 600; i++) step();
    check("R6 stop bit after reset freezes", n_out, 0);

    // R2 R4: every divide code, sources alternating; xtal 1024 ticks, stage1 512
    for (int d = 0; d < 8; d++) begin
      int sel = d % 4;
      int ticks = (sel >= 2) ? 512 : 1024;
      window(16'((sel << 14) | (d << 11) | ((7 - d) << 2) | 2), 1024, ticks >> (d + 1),
             (sel >= 2) ? "R2 R4 stage1 source pulse count" : "R2 R4 xtal source pulse count");
    end

    // R6: explicit stop in normal mode
    window(16'h0100 | 16'(3 << 11), 1024, 0, "R6 stop bit freezes normal mode");

    // R5 R3: calendar mode, every interval code, stop bit set and xtal source (ignored)
    cal_mode = 1;
    for (int i = 0; i < 8; i++)
      window(16'(((i % 2) << 14) | (i << 11) | 16'h0100 | (i << 2) | 2), 1024, 4,
             "R5 R6 calendar ratio 128 ignoring src/div/stop");
    cal_hold = 1;
    window(16'h0000, 1024, 0, "R6 calendar hold freezes");
    cal_hold = 0;
    cal_mode = 0;

    // R9: clear flag every cycle while interval events every other tick
    x_on = 0; s_on = 0;
    wr(16'h0002);
    x_on = 1;
    for (int i = 0; i < 40; i++) wr(16'h0002);
    x_on = 0;
    step(); step();

    // R7: reserved bits
    wr(16'hFFFF); step(); step();
    check("R7 reserved bits read zero", int'(ctl_rdata), 16'hF91F);
    // R8: gating
    wr(16'h0101); step(); step();
    check("R8 flag without enable keeps irq low", int'(irq), 0);
    wr(16'h0103); step(); step();
    check("R8 flag with enable raises irq", int'(irq), 1);
    wr(16'h0102); step(); step();
    check("R8 R9 software clear lowers irq", int'(irq), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule